// File: doc/BRIEF.md
# Difference-of-Gaussian Extremum Detector

This block finds scale-space keypoints in a streamed grayscale frame. Four copies of the same frame arrive together, one pixel per accepted beat in raster order. The copies are blurred at four rising smoothing strengths, with nominal sigma values of 1.6, 2.26, 3.2 and 4.5. For each beat the block subtracts adjacent copies and gets three difference levels. Level 0, the top level, is copy 0 minus copy 1. Level 1, the middle level, is copy 1 minus copy 2. Level 2, the bottom level, is copy 2 minus copy 3.

Each level goes into its own pair of line stores and a 3x3 sliding window. Together the three windows form a 3x3x3 cube. The centre of the middle-level window is the candidate. It is reported when it is strictly above all 26 values around it in the cube, or strictly below all of them.

A report is a one-cycle pulse carrying the candidate's column and row. Frame width and height are parameters. A frame-start strobe realigns the coordinate counters at any time.

Top module: `dog_keypoint_detector`

## Requirements
- R1: Each difference level is a 9-bit signed value. Input pairs at the extremes of the 8-bit range (0 against 255) are compared with their true sign and size, with no wrap-around.
- R2: A middle-level pixel that is strictly greater than its 26 neighbours is reported. The neighbours are 9 in the top level, the 8 around it in the middle level, and 9 in the bottom level.
- R3: A middle-level pixel that is strictly smaller than its 26 neighbours is reported.
- R4: A candidate that equals any one of its 26 neighbours is not reported. A frame where every level is flat produces no report.
- R5: Pixels in row 0, row FRAME_H-1, column 0 and column FRAME_W-1 are never reported.
- R6: A report is `kp_valid` high for one cycle, with `kp_col`/`kp_row` giving the candidate's own coordinates. It appears exactly two clock edges after the edge that accepts the pixel at (column+1, row+1).
- R7: When `frame_start` is high, the column and row counters return to zero and any report still in the pipeline is dropped. A pixel accepted in the same cycle is taken as column 0, row 0.
- R8: Cycles with `pix_valid` low change neither the counters nor the windows. A frame delivered with idle gaps gives the same reports as one delivered without gaps.
- R9: During reset and after it, `kp_valid` is low until a keypoint is found.
- R10: After the pixel at column FRAME_W-1 the column returns to 0 and the row advances. After the last pixel of a frame both counters return to 0, so frames can follow one another without `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Realigns the counters to the frame origin and drops pending reports |
| pix_valid | input | 1 | The four blur inputs carry a pixel this cycle |
| blur0 | input | PIX_W | Least-blurred copy |
| blur1 | input | PIX_W | Second copy |
| blur2 | input | PIX_W | Third copy |
| blur3 | input | PIX_W | Most-blurred copy |
| kp_valid | output | 1 | Keypoint found, one-cycle pulse |
| kp_col | output | COL_W | Keypoint column |
| kp_row | output | ROW_W | Keypoint row |

## Verification
The embedded assertions check several properties on every cycle:
- no report ever lands on the frame border;
- each report follows an accepted pixel by exactly two edges;
- a frame-start strobe is never followed by a report;
- the counters hold through idle cycles and wrap after the last column.

Other behaviour can only be shown by the bench's scenarios, which compare the reported positions against a keypoint model computed from the same frames:
- whether a cube really holds a strict maximum or minimum;
- rejection on ties;
- the exact sign and size of differences taken at the ends of the pixel range;
- equal results with and without input gaps.

// File: rtl/dog_kp_pkg.sv
package dog_kp_pkg;
  localparam int PIX_W_DEF = 8;
  localparam int N_BLUR    = 4;
  localparam int N_LVL     = N_BLUR - 1;
  localparam int WIN       = 3;
  localparam int WIN_N     = WIN * WIN;
  localparam int CTR_IDX   = WIN_N / 2;
endpackage

// File: rtl/dog_diff_stage.sv
module dog_diff_stage #(
  parameter int PIX_W = dog_kp_pkg::PIX_W_DEF,
  parameter int DW    = PIX_W + 1
) (
  input  logic [dog_kp_pkg::N_BLUR*PIX_W-1:0] blur_flat,
  output logic [dog_kp_pkg::N_LVL*DW-1:0]     lvl_flat
);
  import dog_kp_pkg::*;

  // one extra bit keeps every difference of two unsigned pixels exact
  for (genvar j = 0; j < N_LVL; j++) begin : g_lvl
    logic [DW-1:0] a_ext, b_ext;
    assign a_ext = {1'b0, blur_flat[j*PIX_W +: PIX_W]};
    assign b_ext = {1'b0, blur_flat[(j+1)*PIX_W +: PIX_W]};
    assign lvl_flat[j*DW +: DW] = a_ext - b_ext;
  end
endmodule

// File: rtl/dog_line_window.sv
module dog_line_window #(
  parameter int FRAME_W = 320,
  parameter int DW      = 9,
  parameter int COL_W   = $clog2(FRAME_W)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                shift_en,
  input  logic [COL_W-1:0]                    col_idx,
  input  logic [DW-1:0]                       din,
  output logic [dog_kp_pkg::WIN_N*DW-1:0]     win_flat
);
  import dog_kp_pkg::*;

  // window slot (rr, cc) sits at index rr*WIN+cc; rr 0 is the oldest row,
  // cc 0 the oldest column, so the centre sits at CTR_IDX
  logic [DW-1:0]        line_near [FRAME_W];
  logic [DW-1:0]        line_far  [FRAME_W];
  logic [WIN_N*DW-1:0]  win_q, win_d;
  logic [WIN*DW-1:0]    new_col;

  assign new_col = {din, line_near[col_idx], line_far[col_idx]};

  always_ff @(posedge clk) begin
    if (shift_en) begin
      line_near[col_idx] <= din;
      line_far[col_idx]  <= line_near[col_idx];
    end
  end

  always_comb begin
    win_d = win_q;
    for (int rr = 0; rr < WIN; rr++) begin
      for (int cc = 0; cc < WIN - 1; cc++) begin
        win_d[(rr*WIN+cc)*DW +: DW] = win_q[(rr*WIN+cc+1)*DW +: DW];
      end
      win_d[(rr*WIN+WIN-1)*DW +: DW] = new_col[rr*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        win_q <= '0;
    else if (shift_en) win_q <= win_d;
  end

  assign win_flat = win_q;
endmodule

// File: rtl/dog_extremum_cmp.sv
module dog_extremum_cmp #(
  parameter int DW = 9
) (
  input  logic [dog_kp_pkg::WIN_N*DW-1:0] top_win,
  input  logic [dog_kp_pkg::WIN_N*DW-1:0] mid_win,
  input  logic [dog_kp_pkg::WIN_N*DW-1:0] bot_win,
  output logic                            is_ext
);
  import dog_kp_pkg::*;

  logic signed [DW-1:0] ctr;
  logic                 above_all, below_all;

  assign ctr = $signed(mid_win[CTR_IDX*DW +: DW]);

  always_comb begin
    above_all = 1'b1;
    below_all = 1'b1;
    for (int i = 0; i < WIN_N; i++) begin
      if (!(ctr > $signed(top_win[i*DW +: DW]))) above_all = 1'b0;
      if (!(ctr < $signed(top_win[i*DW +: DW]))) below_all = 1'b0;
      if (!(ctr > $signed(bot_win[i*DW +: DW]))) above_all = 1'b0;
      if (!(ctr < $signed(bot_win[i*DW +: DW]))) below_all = 1'b0;
      if (i != CTR_IDX) begin
        if (!(ctr > $signed(mid_win[i*DW +: DW]))) above_all = 1'b0;
        if (!(ctr < $signed(mid_win[i*DW +: DW]))) below_all = 1'b0;
      end
    end
  end

  assign is_ext = above_all | below_all;
endmodule

// File: rtl/dog_keypoint_detector.sv
module dog_keypoint_detector #(
  parameter int FRAME_W = 320,
  parameter int FRAME_H = 240,
  parameter int PIX_W   = dog_kp_pkg::PIX_W_DEF,
  parameter int COL_W   = $clog2(FRAME_W),
  parameter int ROW_W   = $clog2(FRAME_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] blur0,
  input  logic [PIX_W-1:0] blur1,
  input  logic [PIX_W-1:0] blur2,
  input  logic [PIX_W-1:0] blur3,
  output logic             kp_valid,
  output logic [COL_W-1:0] kp_col,
  output logic [ROW_W-1:0] kp_row
);
  import dog_kp_pkg::*;

  localparam int DW = PIX_W + 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(FRAME_W - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(FRAME_H - 1);

  // ---------------- position counters ----------------
  logic [COL_W-1:0] col_q, col_d, col_cur;
  logic [ROW_W-1:0] row_q, row_d, row_cur;

  always_comb begin
    col_cur = frame_start ? '0 : col_q;
    row_cur = frame_start ? '0 : row_q;
    col_d   = col_cur;
    row_d   = row_cur;
    if (pix_valid) begin
      if (col_cur == COL_LAST) begin
        col_d = '0;
        row_d = (row_cur == ROW_LAST) ? '0 : row_cur + ROW_W'(1);
      end else begin
        col_d = col_cur + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (pix_valid || frame_start) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  // ---------------- difference levels and windows ----------------
  logic [N_BLUR*PIX_W-1:0] blur_flat;
  logic [N_LVL*DW-1:0]     lvl_flat;
  logic [WIN_N*DW-1:0]     win_flat [N_LVL];

  assign blur_flat = {blur3, blur2, blur1, blur0};

  dog_diff_stage #(.PIX_W(PIX_W), .DW(DW)) diff_i (
    .blur_flat (blur_flat),
    .lvl_flat  (lvl_flat)
  );

  for (genvar l = 0; l < N_LVL; l++) begin : g_win
    dog_line_window #(.FRAME_W(FRAME_W), .DW(DW), .COL_W(COL_W)) win_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (pix_valid),
      .col_idx  (col_cur),
      .din      (lvl_flat[l*DW +: DW]),
      .win_flat (win_flat[l])
    );
  end

  // ---------------- stage 1 tag: position of the newest window column ----
  logic             s1_valid_q, s1_valid_d;
  logic [COL_W-1:0] s1_col_q;
  logic [ROW_W-1:0] s1_row_q;

  assign s1_valid_d = pix_valid & ~frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid_q <= 1'b0;
    else        s1_valid_q <= s1_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_col_q <= '0;
      s1_row_q <= '0;
    end else if (pix_valid) begin
      s1_col_q <= col_cur;
      s1_row_q <= row_cur;
    end
  end

  // ---------------- cube test and output register ----------------
  logic             is_ext;
  logic             kp_valid_d;
  logic [COL_W-1:0] kp_col_d;
  logic [ROW_W-1:0] kp_row_d;

  dog_extremum_cmp #(.DW(DW)) cmp_i (
    .top_win (win_flat[0]),
    .mid_win (win_flat[1]),
    .bot_win (win_flat[2]),
    .is_ext  (is_ext)
  );

  // the window is complete only once two earlier rows and columns exist
  assign kp_valid_d = s1_valid_q & ~frame_start & is_ext &
                      (s1_col_q >= COL_W'(2)) & (s1_row_q >= ROW_W'(2));
  assign kp_col_d   = s1_col_q - COL_W'(1);
  assign kp_row_d   = s1_row_q - ROW_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kp_valid <= 1'b0;
    else        kp_valid <= kp_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kp_col <= '0;
      kp_row <= '0;
    end else if (s1_valid_q) begin
      kp_col <= kp_col_d;
      kp_row <= kp_row_d;
    end
  end

  // ---------------- assertions ----------------
  assert_interior_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kp_valid |-> (kp_col >= COL_W'(1) && kp_col < COL_LAST &&
                  kp_row >= ROW_W'(1) && kp_row < ROW_LAST));

  assert_two_edge_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kp_valid |-> $past(pix_valid, 2));

  assert_start_drops_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !kp_valid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !frame_start) |=> ($stable(col_q) && $stable(row_q)));

  assert_column_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !frame_start && col_q == COL_LAST) |=> (col_q == '0));
endmodule

// File: tb/dog_keypoint_detector_tb_top.sv
`timescale 1ns/1ps
module dog_keypoint_detector_tb_top;
  localparam int W = 8;
  localparam int H = 6;
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(H);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_start;
  logic          pix_valid;
  logic [7:0]    blur0, blur1, blur2, blur3;
  logic          kp_valid;
  logic [CW-1:0] kp_col;
  logic [RW-1:0] kp_row;

  always #4 clk = ~clk;

  dog_keypoint_detector #(.FRAME_W(W), .FRAME_H(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .blur0(blur0), .blur1(blur1), .blur2(blur2), .blur3(blur3),
    .kp_valid(kp_valid), .kp_col(kp_col), .kp_row(kp_row)
  );

  int g [4][H][W];
  int beat_cyc [H][W];
  int rec_col [64];
  int rec_row [64];
  int rec_cyc [64];
  int n_rec;
  int cyc;
  int n_checks;
  int n_errors;
  int lfsr;
  bit done;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && kp_valid === 1'b1 && n_rec < 64) begin
      rec_col[n_rec] = int'(kp_col);
      rec_row[n_rec] = int'(kp_row);
      rec_cyc[n_rec] = cyc;
      n_rec = n_rec + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd8();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    return lfsr & 255;
  endfunction

  function automatic int lvl(input int l, input int r, input int c);
    return g[l][r][c] - g[l+1][r][c];
  endfunction

  function automatic bit is_kp(input int r, input int c);
    int ctr, v;
    bit gt, lt;
    if (r < 1 || r > H-2 || c < 1 || c > W-2) return 0;
    ctr = lvl(1, r, c);
    gt = 1; lt = 1;
    for (int l = 0; l < 3; l++)
      for (int dr = -1; dr <= 1; dr++)
        for (int dc = -1; dc <= 1; dc++) begin
          if (l == 1 && dr == 0 && dc == 0) continue;
          v = lvl(l, r+dr, c+dc);
          if (!(v < ctr)) gt = 0;
          if (!(v > ctr)) lt = 0;
        end
    return gt | lt;
  endfunction

  task automatic fill(input int v);
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) g[l][r][c] = v;
  endtask

  // leaves the last beat on the inputs; caller closes the stream
  task automatic drive_pixels(input int n_beats, input bit gaps);
    for (int p = 0; p < n_beats; p++) begin
      int r, c;
      r = p / W; c = p % W;
      @(negedge clk);
      pix_valid = 1'b1;
      blur0 = 8'(g[0][r][c]); blur1 = 8'(g[1][r][c]);
      blur2 = 8'(g[2][r][c]); blur3 = 8'(g[3][r][c]);
      beat_cyc[r][c] = cyc;
      if (gaps && (rnd8() & 1) && p != n_beats-1) begin
        @(negedge clk);
        pix_valid = 1'b0;
        blur0 = 8'(rnd8()); blur1 = 8'(rnd8());
      end
    end
  endtask

  task automatic run_and_check(input string req, input bit gaps);
    int exp_cnt;
    n_rec = 0;
    drive_pixels(W*H, gaps);
    @(negedge clk);
    pix_valid = 1'b0;
    repeat (4) @(negedge clk);
    exp_cnt = 0;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) exp_cnt += is_kp(r, c);
    chk(n_rec == exp_cnt, req, n_rec, exp_cnt, "keypoint count");
    for (int i = 0; i < n_rec && i < 64; i++) begin
      chk(is_kp(rec_row[i], rec_col[i]), req, rec_row[i]*100 + rec_col[i], -1,
          "report at a non-extremum (row*100+col)");
      chk(rec_row[i] + 1 < H && rec_col[i] + 1 < W &&
          rec_cyc[i] - beat_cyc[rec_row[i]+1][rec_col[i]+1] == 2, "R6",
          rec_cyc[i] - beat_cyc[(rec_row[i]+1) % H][(rec_col[i]+1) % W], 2, "report latency");
    end
  endtask

  task automatic t_reset();
    chk(kp_valid == 1'b0, "R9", int'(kp_valid), 0, "kp_valid in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(kp_valid == 1'b0, "R9", int'(kp_valid), 0, "kp_valid after reset");
  endtask

  task automatic t_flat();
    fill(90);
    run_and_check("R4", 0);
    chk(n_rec == 0, "R4", n_rec, 0, "flat frame reports");
  endtask

  task automatic t_max();
    fill(50);
    g[1][3][4] = 200;
    run_and_check("R2", 0);
    chk(n_rec == 1 && rec_col[0] == 4 && rec_row[0] == 3, "R2",
        rec_row[0]*100 + rec_col[0], 304, "max position row*100+col");
  endtask

  task automatic t_min();
    fill(50);
    g[2][2][2] = 200;
    run_and_check("R3", 0);
    chk(n_rec == 1 && rec_col[0] == 2 && rec_row[0] == 2, "R3",
        rec_row[0]*100 + rec_col[0], 202, "min position row*100+col");
  endtask

  task automatic t_border();
    fill(50);
    g[1][3][0] = 200; g[1][0][3] = 200; g[1][5][5] = 200; g[2][2][7] = 200;
    run_and_check("R5", 0);
    chk(n_rec == 0, "R5", n_rec, 0, "border reports");
  endtask

  task automatic t_tie();
    fill(50);
    g[1][3][4] = 200; g[1][3][5] = 200;
    run_and_check("R4", 0);
    chk(n_rec == 0, "R4", n_rec, 0, "tied pair reports");
  endtask

  task automatic t_extremes();
    fill(0);
    g[1][2][3] = 255;
    g[2][3][5] = 255;
    run_and_check("R1", 0);
    chk(n_rec == 2, "R1", n_rec, 2, "full-range extrema");
  endtask

  task automatic t_random();
    int first;
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) g[l][r][c] = rnd8();
    run_and_check("R8", 0);
    first = n_rec;
    run_and_check("R8", 1);
    chk(n_rec == first, "R8", n_rec, first, "gapped vs dense report count");
  endtask

  task automatic t_back_to_back();
    fill(50);
    g[1][2][2] = 220;
    run_and_check("R10", 0);
    fill(50);
    g[2][4][6] = 10; g[2][4][6] = 240;
    run_and_check("R10", 1);
    chk(n_rec == 1 && rec_row[0] == 4 && rec_col[0] == 6, "R10",
        rec_row[0]*100 + rec_col[0], 406, "second frame position");
  endtask

  task automatic t_frame_start();
    fill(50);
    g[1][3][4] = 200;
    n_rec = 0;
    drive_pixels(4*W + 6, 0);
    @(negedge clk);
    pix_valid = 1'b0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(kp_valid == 1'b0, "R7", int'(kp_valid), 0, "pending report after frame_start");
    repeat (3) @(negedge clk);
    chk(n_rec == 0, "R7", n_rec, 0, "reports from aborted frame");
    fill(50);
    g[2][2][2] = 200;
    run_and_check("R7", 0);
    chk(n_rec == 1 && rec_row[0] == 2 && rec_col[0] == 2, "R7",
        rec_row[0]*100 + rec_col[0], 202, "position after restart");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0; n_errors = 0; n_rec = 0; cyc = 0; lfsr = 16'hACE1; done = 0;
    rst_n = 1'b0; frame_start = 1'b0; pix_valid = 1'b0;
    blur0 = '0; blur1 = '0; blur2 = '0; blur3 = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_flat();
    t_max();
    t_min();
    t_border();
    t_tie();
    t_extremes();
    t_random();
    t_back_to_back();
    t_frame_start();
    finish_run();
  end
endmodule